// File: doc/BRIEF.md
# Pulser Run Controller

This block is the front-panel controller that sits between three push buttons and a multi-program waveform engine for an ultrasound pulser. It filters the buttons for select, start and stop, and keeps track of which of the stored programs is selected. It lights one indicator per program, a run indicator and a fault indicator, and it sends one-cycle start and stop commands to the engine. The engine reports two things back: a completion flag, and a flag that marks the running program as continuous-wave. Continuous programs do not end on completion. Only the stop button ends them.

A digital over-voltage flag comes from an external comparator. While it is high, the controller suspends the active run. It raises a pause level to the engine, which holds the engine's position, and it forces the drive word toward the pulser to all zeros. When the flag drops, the run resumes without a new start command. Select presses have no effect while a run is active or suspended.

Top module: `pulser_run_ctrl`

## Requirements
- R1: After reset, program 0 is selected (`prog_led_o` = 4'b0001, `eng_prog_o` = 0), the run and fault indicators are off, no command is issued and `wave_o` is zero.
- R2: In idle, each select press moves the selection to the next program, wrapping from the last to 0. `prog_led_o` has exactly one bit set, at bit position `eng_prog_o`.
- R3: A button counts as pressed only after its synchronized level has been high for DEB_LEN consecutive cycles, and only on that rising transition. A shorter pulse is ignored, and a long hold counts once.
- R4: A start press in idle issues exactly one `eng_start_o` pulse and turns the run indicator on. `eng_prog_o` carries the selected program.
- R5: During a run with `eng_cont_i` low, a cycle with `eng_done_i` high ends the run. The run indicator goes off and no stop command is issued.
- R6: During a run with `eng_cont_i` high, `eng_done_i` is ignored. A stop press issues one `eng_stop_o` pulse and turns the run indicator off.
- R7: Select presses while running or suspended leave the selection unchanged.
- R8: When the synchronized over-voltage flag is high during a run, `eng_pause_o` is high, `wave_o` is zero, the fault and run indicators are on, and `eng_done_i` is ignored.
- R9: When the over-voltage flag drops, the run resumes with `eng_pause_o` low and `wave_o` following `wave_i`, and no new start command is issued.
- R10: `wave_o` equals `wave_i` only while running and not suspended. Otherwise it is zero.
- R11: A stop press in idle and a start press during a run have no effect.
- R12: The fault indicator follows the over-voltage flag in every state, three clock edges after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_sel_i | input | 1 | Raw program-select button |
| btn_go_i | input | 1 | Raw start button |
| btn_halt_i | input | 1 | Raw stop button |
| ovp_i | input | 1 | Asynchronous over-voltage flag |
| eng_done_i | input | 1 | Engine reports program finished |
| eng_cont_i | input | 1 | Engine reports continuous-wave program |
| wave_i | input | WORD_W | Drive word from the engine |
| prog_led_o | output | NPROG | One-hot program indicators |
| run_led_o | output | 1 | Run indicator |
| fault_led_o | output | 1 | Over-voltage indicator |
| eng_prog_o | output | PW | Selected program index |
| eng_start_o | output | 1 | One-cycle start command |
| eng_stop_o | output | 1 | One-cycle stop command |
| eng_pause_o | output | 1 | Hold-position request to the engine |
| wave_o | output | WORD_W | Gated drive word toward the pulser |

## Verification
A wrong run state shows at the ports within one clock edge of the event that caused it. The run indicator, the pause level and the gating of `wave_o` all come straight from that state. A corrupted selection counter shows at once as a wrong or multi-bit `prog_led_o`. A lost or duplicated command appears as a stray or missing start or stop pulse in the command stream. Debounce faults show only after a full filter window, so the stimulus holds each button longer than that window and also sends pulses shorter than it.

// File: rtl/pulser_run_ctrl.sv
module pulser_run_ctrl #(
  parameter int DEB_LEN = 1000,
  parameter int NPROG   = 4,
  parameter int WORD_W  = 16,
  localparam int PW     = (NPROG > 1) ? $clog2(NPROG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              btn_sel_i,
  input  logic              btn_go_i,
  input  logic              btn_halt_i,
  input  logic              ovp_i,
  input  logic              eng_done_i,
  input  logic              eng_cont_i,
  input  logic [WORD_W-1:0] wave_i,
  output logic [NPROG-1:0]  prog_led_o,
  output logic              run_led_o,
  output logic              fault_led_o,
  output logic [PW-1:0]     eng_prog_o,
  output logic              eng_start_o,
  output logic              eng_stop_o,
  output logic              eng_pause_o,
  output logic [WORD_W-1:0] wave_o
);

  localparam int CW = $clog2(DEB_LEN + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HOLD} st_t;

  logic [2:0] btn_raw;
  logic [2:0] press;
  assign btn_raw = {btn_halt_i, btn_go_i, btn_sel_i};

  genvar g;
  generate
    for (g = 0; g < 3; g++) begin : g_btn
      logic m1, m2, stb, stb_d;
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          m1    <= 1'b0;
          m2    <= 1'b0;
          stb   <= 1'b0;
          stb_d <= 1'b0;
          cnt   <= '0;
        end else begin
          m1    <= btn_raw[g];
          m2    <= m1;
          stb_d <= stb;
          if (m2 == stb) begin
            cnt <= '0;
          end else if (cnt == CW'(DEB_LEN - 1)) begin
            stb <= m2;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
      assign press[g] = stb & ~stb_d;
    end
  endgenerate

  logic ov1, ov2, fault_q;
  logic start_q, stop_q;
  logic [PW-1:0] prog;
  st_t state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov1     <= 1'b0;
      ov2     <= 1'b0;
      fault_q <= 1'b0;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      prog    <= '0;
      state   <= ST_IDLE;
    end else begin
      ov1     <= ovp_i;
      ov2     <= ov1;
      fault_q <= ov2;
      start_q <= 1'b0;
      stop_q  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (press[1]) begin
            start_q <= 1'b1;
            state   <= ov2 ? ST_HOLD : ST_RUN;
          end else if (press[0]) begin
            prog <= (prog == PW'(NPROG - 1)) ? '0 : prog + 1'b1;
          end
        end
        ST_RUN: begin
          if (press[2]) begin
            stop_q <= 1'b1;
            state  <= ST_IDLE;
          end else if (ov2) begin
            state <= ST_HOLD;
          end else if (eng_done_i && !eng_cont_i) begin
            state <= ST_IDLE;
          end
        end
        ST_HOLD: begin
          if (press[2]) begin
            stop_q <= 1'b1;
            state  <= ST_IDLE;
          end else if (!ov2) begin
            state <= ST_RUN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign prog_led_o  = NPROG'(1) << prog;
  assign eng_prog_o  = prog;
  assign run_led_o   = (state != ST_IDLE);
  assign eng_pause_o = (state == ST_HOLD);
  assign fault_led_o = fault_q;
  assign eng_start_o = start_q;
  assign eng_stop_o  = stop_q;
  assign wave_o      = (state == ST_RUN) ? wave_i : '0;

endmodule

module pulser_run_ctrl_chk #(
  parameter int NPROG  = 4,
  parameter int WORD_W = 16,
  localparam int PW    = (NPROG > 1) ? $clog2(NPROG) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPROG-1:0]  prog_led_o,
  input logic              run_led_o,
  input logic              fault_led_o,
  input logic [PW-1:0]     eng_prog_o,
  input logic              eng_start_o,
  input logic              eng_stop_o,
  input logic              eng_pause_o,
  input logic [WORD_W-1:0] wave_o
);

  // R2
  prog_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(prog_led_o) == 1 && prog_led_o[eng_prog_o]);

  // R4
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_o |=> !eng_start_o);

  // R4
  start_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_o |-> run_led_o && !eng_stop_o);

  // R6
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_stop_o |-> !run_led_o && $past(run_led_o));

  // R7
  prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_led_o && $past(run_led_o)) |-> $stable(eng_prog_o));

  // R8
  pause_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_pause_o |-> wave_o == '0 && run_led_o && fault_led_o);

  // R10
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_led_o |-> wave_o == '0);

endmodule

bind pulser_run_ctrl pulser_run_ctrl_chk #(.NPROG(NPROG), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/pulser_run_ctrl_tb.sv
module pulser_run_ctrl_tb;

  localparam int DEB = 8;
  localparam int HOLD_CYC = DEB + 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_sel = 0, btn_go = 0, btn_halt = 0, ovp = 0, done = 0, cont = 0;
  logic [15:0] wave_in = 16'h0;
  logic [3:0] prog_led;
  logic run_led, fault_led, start, stop, pause;
  logic [1:0] prog;
  logic [15:0] wave_out;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_q[$];
  bit reported = 0;

  always #5 clk = ~clk;

  pulser_run_ctrl #(.DEB_LEN(DEB), .NPROG(4), .WORD_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .btn_sel_i(btn_sel), .btn_go_i(btn_go),
    .btn_halt_i(btn_halt), .ovp_i(ovp), .eng_done_i(done), .eng_cont_i(cont),
    .wave_i(wave_in), .prog_led_o(prog_led), .run_led_o(run_led),
    .fault_led_o(fault_led), .eng_prog_o(prog), .eng_start_o(start),
    .eng_stop_o(stop), .eng_pause_o(pause), .wave_o(wave_out));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor: command pulses (start = 4 + prog, stop = 8 + prog)
  // R4 R6 R11: every command must match the next expected item
  always @(negedge clk) begin
    if (rst_n && (start || stop)) begin
      int got;
      got = (start ? 4 : 8) + int'(prog);
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R4/R6/R11 unexpected command actual=%0d expected=none", got);
      end else begin
        int e;
        e = exp_q.pop_front();
        if (e != got) begin
          n_bad++;
          $display("FAIL R4/R6 command actual=%0d expected=%0d", got, e);
        end
      end
    end
  end

  task automatic press(int which, int len = HOLD_CYC);
    @(negedge clk);
    case (which)
      0: btn_sel = 1;
      1: btn_go = 1;
      default: btn_halt = 1;
    endcase
    wait_cyc(len);
    btn_sel = 0; btn_go = 0; btn_halt = 0;
    wait_cyc(HOLD_CYC);
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1;
    @(negedge clk); done = 0;
    wait_cyc(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(2);
    // R1 reset state
    check("R1 prog_led", prog_led, 4'b0001);
    check("R1 prog", prog, 0);
    check("R1 run_led", run_led, 0);
    check("R1 fault_led", fault_led, 0);
    check("R1 wave_o", wave_out, 0);

    // R3 short glitch ignored
    press(0, 3);
    check("R3 glitch", prog_led, 4'b0001);

    // R2 cycling through programs with wrap
    press(0); check("R2 sel1", prog_led, 4'b0010);
    press(0); check("R2 sel2", prog_led, 4'b0100);
    press(0); check("R2 sel3", prog_led, 4'b1000);
    press(0); check("R2 wrap", prog_led, 4'b0001);
    check("R2 prog", prog, 0);

    // R3 long hold counts once
    press(0, 4 * DEB);
    check("R3 long hold", prog_led, 4'b0010);

    // R11 stop in idle does nothing
    press(2);
    check("R11 halt idle", run_led, 0);

    // R4 start program 1, finite
    wave_in = 16'hA5A5;
    cont = 0;
    exp_q.push_back(4 + 1);
    press(1);
    check("R4 run_led", run_led, 1);
    check("R10 wave pass", wave_out, 16'hA5A5);
    press(0);
    check("R7 sel ignored", prog_led, 4'b0010);
    press(1);
    check("R11 go while run", run_led, 1);
    pulse_done();
    check("R5 done ends", run_led, 0);
    check("R10 idle zero", wave_out, 0);

    // R6 continuous program
    cont = 1;
    exp_q.push_back(4 + 1);
    press(1);
    pulse_done();
    check("R6 done ignored", run_led, 1);
    exp_q.push_back(8 + 1);
    press(2);
    check("R6 stop", run_led, 0);
    cont = 0;

    // R8 R9 suspension and resume
    wave_in = 16'h3C3C;
    exp_q.push_back(4 + 1);
    press(1);
    @(negedge clk); ovp = 1;
    wait_cyc(6);
    check("R8 pause", pause, 1);
    check("R8 wave zero", wave_out, 0);
    check("R8 fault", fault_led, 1);
    check("R8 run kept", run_led, 1);
    pulse_done();
    check("R8 done ignored", run_led, 1);
    ovp = 0;
    wait_cyc(6);
    check("R9 unpause", pause, 0);
    check("R9 wave back", wave_out, 16'h3C3C);
    check("R12 fault clear", fault_led, 0);
    pulse_done();
    check("R5 done after resume", run_led, 0);

    // R12 fault in idle, no pause
    @(negedge clk); ovp = 1;
    wait_cyc(6);
    check("R12 fault idle", fault_led, 1);
    check("R12 no pause idle", pause, 0);

    // R8 start while flag high goes straight to suspension
    exp_q.push_back(4 + 1);
    press(1);
    check("R8 start held", pause, 1);
    ovp = 0;
    wait_cyc(6);
    check("R9 resume", wave_out, 16'h3C3C);
    exp_q.push_back(8 + 1);
    press(2);
    check("R6 stop finite", run_led, 0);

    // R4 R6 all expected commands seen
    check("R4/R6 queue empty", exp_q.size(), 0);
    report();
  end

endmodule